// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block manages one processor's private, direct-mapped cache in a shared-bus system that keeps copies coherent by updating them, never by invalidating them. Lines can be held by several caches at once. When a processor writes a line that others may hold, the new word is broadcast on the bus to the other caches only. Memory is not updated by that broadcast. The last writer of a shared line becomes its owner and must write it back on eviction.

Shared status comes from a wired-OR sharing signal on the bus. Every cache that holds the addressed line raises it while snooping a fill or a word update. The controller samples it when one of its own transactions is granted. On the processor side there is a held request that ends with a one-cycle done pulse. On the bus side there is a request/grant master port: each granted transaction completes in its grant cycle and moves a whole line in parallel. There is also a snoop port, which supplies owned lines, merges broadcast words and drives the sharing signal.

Top module: `wupd_cache_ctrl`

## Requirements
- R1: After reset every line is empty. The block raises no bus request and no done pulse, and a snoop of any address gives snp_shared=0 and snp_supply=0.
- R2: A processor read that misses issues bus_cmd=0 (line fill for read) at the line address, which is the word address with the low OFS_W bits cleared. The request is held with stable cmd and address until granted. The returned word is the one at the word offset. The line then becomes shared-clean if bus_shared_in was 1 at the grant, otherwise valid-exclusive.
- R3: A write hit on a valid-exclusive or dirty line completes with no bus transaction and leaves the line dirty.
- R4: A write hit on a shared-clean or shared-dirty line issues bus_cmd=2 (word update) carrying the word address and the write data. The line then becomes dirty if bus_shared_in was 0 at the grant, otherwise shared-dirty.
- R5: A snooped bus_cmd=0 that hits raises snp_shared. A dirty or shared-dirty holder also raises snp_supply, drives the whole line on snp_blk and becomes shared-dirty. A valid-exclusive or shared-clean holder becomes shared-clean.
- R6: A snooped bus_cmd=1 (line fill for write) that hits raises snp_shared, and snp_supply too if the line is dirty or shared-dirty. The holder becomes shared-clean.
- R7: A snooped bus_cmd=2 that hits overwrites the addressed word with snp_word, raises snp_shared and leaves the line shared-clean.
- R8: A processor write that misses issues bus_cmd=1 and merges the write into the returned line. With bus_shared_in=0 the line becomes dirty and no broadcast follows. With bus_shared_in=1 the line becomes shared-dirty and a bus_cmd=2 word update follows.
- R9: On a miss whose victim line is dirty or shared-dirty, a bus_cmd=3 write-back of the whole victim line to the victim's line address comes before the fill. A clean victim is dropped without a bus transaction.
- R10: When a snoop hit and a processor access arrive in the same cycle, the snoop is applied first. A read of a word that the snoop updates returns the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: tag, index, word offset |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 0 fill-read, 1 fill-write, 2 word update, 3 write-back |
| bus_addr | output | ADDR_W | Transaction word address (offset 0 for line commands) |
| bus_wblk | output | WORDS*DATA_W | Line written back |
| bus_wword | output | DATA_W | Word broadcast by an update |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Wired-OR sharing signal during the grant |
| bus_rblk | input | WORDS*DATA_W | Fill line from memory or the owning cache |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_word | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache owns the line and drives snp_blk |
| snp_blk | output | WORDS*DATA_W | Owned line contents |

## Verification
The two functions that can collide are a snoop hit and a waiting processor access, because both use the same line arrays. The bench raises a snooped word update to a cached line and a processor read of that very word on the same clock edge. The read must come back one cycle later with the snooped value and not the stale one. A one-cycle stall when a snoop lands on an idle controller is also checked through an assertion.

// File: rtl/wupd_cache_ctrl.sv
module wupd_cache_ctrl #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 2,
  parameter int OFS_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cpu_req,
  input  logic                             cpu_we,
  input  logic [ADDR_W-1:0]                cpu_addr,
  input  logic [DATA_W-1:0]                cpu_wdata,
  output logic [DATA_W-1:0]                cpu_rdata,
  output logic                             cpu_done,
  output logic                             bus_req,
  output logic [1:0]                       bus_cmd,
  output logic [ADDR_W-1:0]                bus_addr,
  output logic [(1<<OFS_W)*DATA_W-1:0]     bus_wblk,
  output logic [DATA_W-1:0]                bus_wword,
  input  logic                             bus_gnt,
  input  logic                             bus_shared_in,
  input  logic [(1<<OFS_W)*DATA_W-1:0]     bus_rblk,
  input  logic                             snp_valid,
  input  logic [1:0]                       snp_cmd,
  input  logic [ADDR_W-1:0]                snp_addr,
  input  logic [DATA_W-1:0]                snp_word,
  output logic                             snp_shared,
  output logic                             snp_supply,
  output logic [(1<<OFS_W)*DATA_W-1:0]     snp_blk
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFS_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam int BLK_W = WORDS * DATA_W;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPD = 2'd2, C_WB = 2'd3;

  typedef enum logic [2:0] {L_NP, L_VE, L_SC, L_SD, L_DY} lst_t;
  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_UPD} fsm_t;

  logic [TAG_W-1:0] tag_q [LINES];
  lst_t             st_q  [LINES];
  logic [BLK_W-1:0] blk_q [LINES];
  fsm_t             fsm_q;

  function automatic logic [BLK_W-1:0] put_word(input logic [BLK_W-1:0] b,
                                                input logic [OFS_W-1:0] o,
                                                input logic [DATA_W-1:0] w);
    put_word = b;
    put_word[o*DATA_W +: DATA_W] = w;
  endfunction

  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] c_idx = cpu_addr[OFS_W +: IDX_W];
  wire [OFS_W-1:0] c_ofs = cpu_addr[OFS_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] s_idx = snp_addr[OFS_W +: IDX_W];
  wire [OFS_W-1:0] s_ofs = snp_addr[OFS_W-1:0];

  lst_t c_st, s_st;
  assign c_st = st_q[c_idx];
  assign s_st = st_q[s_idx];

  wire c_hit   = (c_st != L_NP) && (tag_q[c_idx] == c_tag);
  wire c_owned = (c_st == L_SD) || (c_st == L_DY);
  wire s_act   = snp_valid && (snp_cmd != C_WB) && (s_st != L_NP) && (tag_q[s_idx] == s_tag);
  wire s_owned = (s_st == L_SD) || (s_st == L_DY);
  wire cpu_go  = cpu_req && !cpu_done && !s_act;

  assign snp_shared = s_act;
  assign snp_supply = s_act && (snp_cmd != C_UPD) && s_owned;
  assign snp_blk    = blk_q[s_idx];

  assign bus_req   = (fsm_q != S_IDLE);
  assign bus_wblk  = blk_q[c_idx];
  assign bus_wword = cpu_wdata;

  always_comb begin
    bus_cmd  = C_UPD;
    bus_addr = cpu_addr;
    case (fsm_q)
      S_WB: begin
        bus_cmd  = C_WB;
        bus_addr = {tag_q[c_idx], c_idx, {OFS_W{1'b0}}};
      end
      S_FILL: begin
        bus_cmd  = cpu_we ? C_RDX : C_RD;
        bus_addr = {c_tag, c_idx, {OFS_W{1'b0}}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= S_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= L_NP;
        tag_q[i] <= '0;
        blk_q[i] <= '0;
      end
    end else begin
      cpu_done <= 1'b0;
      case (fsm_q)
        S_IDLE: if (cpu_go) begin
          if (!c_hit) begin
            fsm_q <= c_owned ? S_WB : S_FILL;
          end else if (!cpu_we) begin
            cpu_rdata <= blk_q[c_idx][c_ofs*DATA_W +: DATA_W];
            cpu_done  <= 1'b1;
          end else if (c_st == L_VE || c_st == L_DY) begin
            blk_q[c_idx] <= put_word(blk_q[c_idx], c_ofs, cpu_wdata);
            st_q[c_idx]  <= L_DY;
            cpu_done     <= 1'b1;
          end else begin
            fsm_q <= S_UPD;
          end
        end
        S_WB: if (bus_gnt) begin
          st_q[c_idx] <= L_NP;
          fsm_q       <= S_FILL;
        end
        S_FILL: if (bus_gnt) begin
          tag_q[c_idx] <= c_tag;
          if (!cpu_we) begin
            blk_q[c_idx] <= bus_rblk;
            st_q[c_idx]  <= bus_shared_in ? L_SC : L_VE;
            cpu_rdata    <= bus_rblk[c_ofs*DATA_W +: DATA_W];
            cpu_done     <= 1'b1;
            fsm_q        <= S_IDLE;
          end else begin
            blk_q[c_idx] <= put_word(bus_rblk, c_ofs, cpu_wdata);
            st_q[c_idx]  <= bus_shared_in ? L_SD : L_DY;
            cpu_done     <= !bus_shared_in;
            fsm_q        <= bus_shared_in ? S_UPD : S_IDLE;
          end
        end
        S_UPD: if (bus_gnt) begin
          blk_q[c_idx] <= put_word(blk_q[c_idx], c_ofs, cpu_wdata);
          st_q[c_idx]  <= bus_shared_in ? L_SD : L_DY;
          cpu_done     <= 1'b1;
          fsm_q        <= S_IDLE;
        end
        default: fsm_q <= S_IDLE;
      endcase
      if (s_act) begin
        case (snp_cmd)
          C_RD:    st_q[s_idx] <= s_owned ? L_SD : L_SC;
          C_UPD: begin
            blk_q[s_idx] <= put_word(blk_q[s_idx], s_ofs, snp_word);
            st_q[s_idx]  <= L_SC;
          end
          default: st_q[s_idx] <= L_SC;
        endcase
      end
    end
  end
endmodule

// File: rtl/wupd_cache_ctrl_chk.sv
module wupd_cache_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_done,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wword,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic              snp_shared,
  input logic              snp_supply
);
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(cpu_req)); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R2
  AST_UPD_CARRIES_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd2) |-> (bus_wword == cpu_wdata)); // R4
  AST_SUPPLY_IMPLIES_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared); // R5
  AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_shared && !bus_req) |=> !cpu_done); // R10
endmodule

bind wupd_cache_ctrl wupd_cache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wdata(cpu_wdata),
  .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_wword(bus_wword), .bus_gnt(bus_gnt), .snp_valid(snp_valid),
  .snp_shared(snp_shared), .snp_supply(snp_supply));

// File: tb/wupd_cache_ctrl_tb.sv
`timescale 1ns/1ps
module wupd_cache_ctrl_tb;
  localparam int AW = 10, DW = 32, BW = 128;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_done, bus_req, bus_gnt = 0, bus_shared_in = 0;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [BW-1:0] bus_wblk, bus_rblk = '0, snp_blk;
  logic [DW-1:0] bus_wword;
  logic snp_valid = 0, snp_shared, snp_supply;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_word = '0;

  always #10 clk = ~clk;

  wupd_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wblk(bus_wblk),
    .bus_wword(bus_wword), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .bus_rblk(bus_rblk), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_word(snp_word), .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_blk(snp_blk));

  typedef struct {
    bit        is_bus;
    bit        chk_data;
    logic [1:0] cmd;
    logic [AW-1:0] addr;
    logic [BW-1:0] data;
    string     rq;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic exp_bus(input logic [1:0] cmd, input logic [AW-1:0] a, input bit cd,
                         input logic [BW-1:0] d, input string rq);
    exp_t e;
    e.is_bus = 1; e.chk_data = cd; e.cmd = cmd; e.addr = a; e.data = d; e.rq = rq;
    sb.push_back(e);
  endtask

  task automatic exp_done(input bit cd, input logic [DW-1:0] d, input string rq);
    exp_t e;
    e.is_bus = 0; e.chk_data = cd; e.cmd = 0; e.addr = 0; e.data = BW'(d); e.rq = rq;
    sb.push_back(e);
  endtask

  // monitor and bus model: grants a waiting request and checks it against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_gnt) begin
      if (sb.size() == 0 || !sb[0].is_bus) begin
        check(0, "unexpected bus transaction", BW'({bus_cmd, bus_addr}), '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({bus_cmd, bus_addr} == {e.cmd, e.addr}, e.rq, BW'({bus_cmd, bus_addr}), BW'({e.cmd, e.addr}));
        if (e.chk_data) begin
          if (e.cmd == 2'd3) check(bus_wblk == e.data, e.rq, bus_wblk, e.data);
          else check(BW'(bus_wword) == e.data, e.rq, BW'(bus_wword), e.data);
        end
      end
      bus_gnt <= 1'b1;
    end else begin
      bus_gnt <= 1'b0;
    end
    if (rst_n && cpu_done) begin
      if (sb.size() == 0 || sb[0].is_bus) begin
        check(0, "unexpected done", BW'(cpu_rdata), '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.chk_data) check(BW'(cpu_rdata) == e.data, e.rq, BW'(cpu_rdata), e.data);
        else check(1'b1, e.rq, '0, '0);
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit shin, input logic [BW-1:0] rblk, input string rq);
    bit got = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    bus_shared_in = shin; bus_rblk = rblk;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (cpu_done) got = 1;
    end
    cpu_req = 0;
    if (!got) check(0, {rq, " no done"}, '0, 1);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] w,
                       input bit exp_sh, input bit exp_sup, input bit cb,
                       input logic [BW-1:0] exp_blk, input string rq);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a; snp_word = w;
    #1;
    check(snp_shared == exp_sh, {rq, " shared"}, BW'(snp_shared), BW'(exp_sh));
    check(snp_supply == exp_sup, {rq, " supply"}, BW'(snp_supply), BW'(exp_sup));
    if (cb) check(snp_blk == exp_blk, {rq, " block"}, snp_blk, exp_blk);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", '0, 1);
    finish_up();
  end

  localparam logic [BW-1:0] RA  = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
  localparam logic [BW-1:0] RB  = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
  localparam logic [BW-1:0] RC  = 128'hC3C3C3C3_C2C2C2C2_C1C1C1C1_C0C0C0C0;
  localparam logic [BW-1:0] RA2 = 128'hD3D3D3D3_D2D2D2D2_D1D1D1D1_D0D0D0D0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: empty after reset
    check(cpu_done == 0 && bus_req == 0, "R1 idle outputs", BW'({cpu_done, bus_req}), '0);
    snoop(2'd0, 10'h004, 0, 0, 0, 0, '0, "R1 snoop empty");

    // R2: read miss, sharing low -> valid-exclusive
    exp_bus(2'd0, 10'h004, 0, '0, "R2 fill cmd");
    exp_done(1, 32'hA1A1A1A1, "R2 read data");
    cpu_op(0, 10'h005, 0, 0, RA, "R2");

    // R3: write hit on valid-exclusive is local
    exp_done(0, 0, "R3 local write");
    cpu_op(1, 10'h005, 32'h11111111, 0, '0, "R3");
    // R5: owner supplies and becomes shared-dirty
    snoop(2'd0, 10'h004, 0, 1, 1, 1, 128'hA3A3A3A3_A2A2A2A2_11111111_A0A0A0A0, "R5 dirty supply");

    // R4: write hit on shared-dirty, sharing high -> stays shared-dirty
    exp_bus(2'd2, 10'h006, 1, BW'(32'h22222222), "R4 broadcast");
    exp_done(0, 0, "R4 done");
    cpu_op(1, 10'h006, 32'h22222222, 1, '0, "R4");
    snoop(2'd0, 10'h004, 0, 1, 1, 1, 128'hA3A3A3A3_22222222_11111111_A0A0A0A0, "R5 shared-dirty supply");

    // R4: sharing low -> dirty; R3: next write local
    exp_bus(2'd2, 10'h007, 1, BW'(32'h33333333), "R4 broadcast last");
    exp_done(0, 0, "R4 done");
    cpu_op(1, 10'h007, 32'h33333333, 0, '0, "R4");
    exp_done(0, 0, "R3 dirty local write");
    cpu_op(1, 10'h004, 32'h44444444, 0, '0, "R3");
    // R6: snooped fill-for-write: supply, go shared-clean
    snoop(2'd1, 10'h004, 0, 1, 1, 1, 128'h33333333_22222222_11111111_44444444, "R6 rdx supply");
    snoop(2'd0, 10'h004, 0, 1, 0, 0, '0, "R6 now shared-clean");

    // R7: snooped update merges word
    snoop(2'd2, 10'h004, 32'h55555555, 1, 0, 0, '0, "R7 update");
    exp_done(1, 32'h55555555, "R7 merged word");
    cpu_op(0, 10'h004, 0, 0, '0, "R7");

    // R10: snoop update and processor read of same word in one cycle
    exp_done(1, 32'h66666666, "R10 snoop first");
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 10'h005;
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 10'h005; snp_word = 32'h66666666;
    #1;
    check(snp_shared == 1, "R10 shared", BW'(snp_shared), 1);
    @(negedge clk);
    snp_valid = 0;
    for (int i = 0; i < 10 && cpu_req; i++) begin
      if (cpu_done) cpu_req = 0;
      else @(negedge clk);
    end
    cpu_req = 0;

    // R9: clean victim dropped; R2: sharing high -> shared-clean
    exp_bus(2'd0, 10'h044, 0, '0, "R9 clean victim no writeback");
    exp_done(1, 32'hB0B0B0B0, "R2 read B");
    cpu_op(0, 10'h044, 0, 1, RB, "R2");
    snoop(2'd0, 10'h044, 0, 1, 0, 0, '0, "R2 shared-clean");
    snoop(2'd0, 10'h004, 0, 0, 0, 0, '0, "R9 old line gone");

    // R8: write miss with sharing high -> shared-dirty plus broadcast
    exp_bus(2'd1, 10'h084, 0, '0, "R8 rdx");
    exp_bus(2'd2, 10'h087, 1, BW'(32'h77777777), "R8 broadcast");
    exp_done(0, 0, "R8 done");
    cpu_op(1, 10'h087, 32'h77777777, 1, RC, "R8");
    snoop(2'd0, 10'h084, 0, 1, 1, 1, 128'h77777777_C2C2C2C2_C1C1C1C1_C0C0C0C0, "R8 shared-dirty");

    // R9: dirty victim written back; R8: sharing low -> dirty, no broadcast
    exp_bus(2'd3, 10'h084, 1, 128'h77777777_C2C2C2C2_C1C1C1C1_C0C0C0C0, "R9 writeback");
    exp_bus(2'd1, 10'h004, 0, '0, "R8 rdx");
    exp_done(0, 0, "R8 done low");
    cpu_op(1, 10'h006, 32'h88888888, 0, RA2, "R8");
    snoop(2'd1, 10'h004, 0, 1, 1, 1, 128'hD3D3D3D3_88888888_D1D1D1D1_D0D0D0D0, "R8 dirty supply");

    // R4: shared-clean write with sharing high -> shared-dirty
    exp_bus(2'd2, 10'h004, 1, BW'(32'h99999999), "R4 sc broadcast");
    exp_done(0, 0, "R4 done");
    cpu_op(1, 10'h004, 32'h99999999, 1, '0, "R4");
    snoop(2'd0, 10'h004, 0, 1, 1, 1, 128'hD3D3D3D3_88888888_D1D1D1D1_99999999, "R4 shared-dirty");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", BW'(sb.size()), '0);
    finish_up();
  end
endmodule